// File: doc/BRIEF.md
# Predicated Vector Carry Propagation Adder

The block adds two long integers, each held as a vector of `N` elements of `W` bits. Element 0 holds the least significant word. All lanes first add their own words in one cycle, with no carry passing between lanes. Each lane's overflow is kept as one bit of an overflow mask. The adder then moves carries upward in further cycles instead of through a long hardware carry chain. The mask, moved up by one lane, serves as a predicate for a masked add-one pass. Each enabled lane adds one to its element and records whether that increment wrapped it again.

Passes continue until the moved-up mask holds no set bit. At that point the result vector holds the low `N*W` bits of the full sum. The carry-out holds bit `N*W` of the sum, and `done` pulses for one cycle. The overflow mask stays visible on a port throughout, so a caller can watch carries move lane by lane.

Top module: `vec_carry_adder`

## Requirements
- R1: After reset, `sum_vec` and `ovf_mask` are all zeros, and `carry_out` and `done` are low.
- R2: The adder accepts `start` in a cycle when no operation is in progress. In the next cycle, each lane i of `sum_vec` equals `(a_i + b_i) mod 2^W`. Lane i occupies bits `[i*W +: W]`. Each `ovf_mask` bit i is the carry out of that lane's addition.
- R3: In each add-one pass, lane i (i >= 1) is incremented modulo `2^W` exactly when `ovf_mask` bit i-1 was set before the pass. Lane 0 is never incremented. A lane whose predicate bit is zero keeps its value.
- R4: Each pass replaces the whole mask. Bit i becomes set only when lane i was incremented from all ones.
- R5: Passes repeat until `ovf_mask` bits `[N-2:0]` are all zero. `done` is then high for exactly one cycle. While `done` is high, `sum_vec` equals `(A + B) mod 2^(N*W)`.
- R6: While `done` is high, `carry_out` equals bit `N*W` of `A + B`. It includes a carry leaving the top lane during the first add or during any pass.
- R7: With k add-one passes, `done` is high in the (k+1)-th cycle after the cycle in which `start` was accepted. When no carry crosses a lane boundary, `done` is high in the first cycle after that cycle.
- R8: The adder ignores `start` while an operation is in progress, including the cycle in which `done` is high. In that case the result of the running operation is unchanged, and no new operation begins.
- R9: While idle and without `start`, `sum_vec`, `ovf_mask` and `carry_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| start | input | 1 | Begin an addition of `a_vec` and `b_vec` |
| a_vec | input | N*W | First operand, lane 0 least significant |
| b_vec | input | N*W | Second operand, lane 0 least significant |
| sum_vec | output | N*W | Result vector, updated by the add and by each pass |
| carry_out | output | 1 | Carry out of the top lane, valid with `done` |
| done | output | 1 | One-cycle pulse when no carry is left to move |
| ovf_mask | output | N | Per-lane overflow bits of the most recent add or pass |

## Verification
The bound checker tests properties that hold on every cycle of every operation:
- the mask only moves upward, bit by bit, during a pass;
- lane 0 is frozen once the first add is over;
- the carry-out never drops during an operation;
- `done` lasts one cycle and returns the adder to idle;
- the idle outputs hold.

Only the bench scenarios can show the arithmetic: the per-lane sums and carries after the first add, the exact increment pattern of a pass, the final wide sum and carry-out, and the pass count. The scenarios cover no carry, a single carry, long all-ones ripples, a carry leaving the top lane, and operands with random values. Only the bench can show that a `start` issued mid-operation, or in the `done` cycle, leaves the running result alone.

// File: rtl/vca_pkg.sv
package vca_pkg;
  typedef enum logic {
    VCA_IDLE = 1'b0,
    VCA_PROP = 1'b1
  } vca_state_e;
endpackage

// File: rtl/vca_lane.sv
// One element of the long integer: loads a+b, or adds its predicate bit.
module vca_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         pred,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] sum_q, sum_n;
  logic         ovf_q, ovf_n;
  logic         en;

  assign en = load | step;

  always_comb begin
    sum_n = sum_q;
    ovf_n = ovf_q;
    if (load) begin
      {ovf_n, sum_n} = {1'b0, a} + {1'b0, b};
    end else if (step) begin
      // a pass always records a fresh overflow bit, even for idle lanes
      sum_n = sum_q + {{(W-1){1'b0}}, pred};
      ovf_n = pred & (&sum_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      sum_q <= sum_n;
      ovf_q <= ovf_n;
    end
  end

  assign sum = sum_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/vca_ctrl.sv
// Sequencer: accepts start, moves the mask up one lane, runs passes, reports done.
module vca_ctrl
  import vca_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] mask,
  output logic         load,
  output logic         step,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] pred,
  output logic         carry_out
);
  vca_state_e state_q, state_n;
  logic       carry_q, carry_n;
  logic       live;

  // lane 0 never receives a carry; lane i takes the overflow of lane i-1
  assign pred[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_pred
    assign pred[i] = mask[i-1];
  end

  assign live = |pred;
  assign busy = (state_q == VCA_PROP);
  assign load = (state_q == VCA_IDLE) & start;
  assign step = busy & live;
  assign done = busy & ~live;

  always_comb begin
    state_n = state_q;
    carry_n = carry_q;
    case (state_q)
      VCA_IDLE: if (start) begin
        state_n = VCA_PROP;
        carry_n = 1'b0;
      end
      VCA_PROP: begin
        if (live) carry_n = carry_q | mask[N-1];
        else      state_n = VCA_IDLE;
      end
      default: state_n = VCA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VCA_IDLE;
      carry_q <= 1'b0;
    end else begin
      state_q <= state_n;
      carry_q <= carry_n;
    end
  end

  // the top bit of the current mask has not yet been folded into carry_q
  assign carry_out = carry_q | mask[N-1];
endmodule

// File: rtl/vec_carry_adder.sv
module vec_carry_adder #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] a_vec,
  input  logic [N*W-1:0] b_vec,
  output logic [N*W-1:0] sum_vec,
  output logic           carry_out,
  output logic           done,
  output logic [N-1:0]   ovf_mask
);
  localparam int TOTAL = N * W;

  logic         load, step, busy;
  logic [N-1:0] pred;
  logic [N-1:0] lane_ovf;
  logic [TOTAL-1:0] lane_sum;

  vca_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mask      (lane_ovf),
    .load      (load),
    .step      (step),
    .busy      (busy),
    .done      (done),
    .pred      (pred),
    .carry_out (carry_out)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    vca_lane #(.W(W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .a     (a_vec[i*W +: W]),
      .b     (b_vec[i*W +: W]),
      .pred  (pred[i]),
      .sum   (lane_sum[i*W +: W]),
      .ovf   (lane_ovf[i])
    );
  end

  assign sum_vec  = lane_sum;
  assign ovf_mask = lane_ovf;
endmodule

// File: rtl/vec_carry_adder_chk.sv
module vec_carry_adder_chk #(
  parameter int N = 8,
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           carry_out,
  input logic [N*W-1:0] sum_vec,
  input logic [N-1:0]   ovf_mask
);
  // R4: a pass can only set bit i when bit i-1 was set before it
  p_mask_moves_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ((ovf_mask & ~($past(ovf_mask) << 1)) == '0));

  // R3: lane 0 never changes during a pass
  p_lane0_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (sum_vec[W-1:0] == $past(sum_vec[W-1:0])));

  // R6: once a carry has left the top lane it stays reported
  p_carry_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && carry_out) |=> carry_out);

  // R5, R8: done is one cycle long and no operation follows it directly
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R9: idle outputs hold
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum_vec) && $stable(ovf_mask) && $stable(carry_out)));
endmodule

bind vec_carry_adder vec_carry_adder_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/vec_carry_adder_test.sv
module vec_carry_adder_test;
  localparam int N = 8;
  localparam int W = 32;
  localparam int T = N * W;
  localparam time CLK_PERIOD = 10ns;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [T-1:0] a_vec, b_vec;
  logic [T-1:0] sum_vec;
  logic         carry_out, done;
  logic [N-1:0] ovf_mask;

  int errors = 0;
  int checks = 0;

  vec_carry_adder #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_vec(a_vec), .b_vec(b_vec),
    .sum_vec(sum_vec), .carry_out(carry_out), .done(done), .ovf_mask(ovf_mask)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [T:0] act, input logic [T:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // number of add-one passes the requirements imply for these operands
  function automatic int exp_passes(input logic [T-1:0] a, input logic [T-1:0] b);
    logic [W-1:0] s [N];
    logic [N-1:0] m, p, nm;
    int k = 0;
    for (int i = 0; i < N; i++) {m[i], s[i]} = {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]};
    p = m << 1;
    while (p != '0) begin
      for (int i = 0; i < N; i++) begin
        nm[i] = p[i] & (&s[i]);
        s[i] = s[i] + {{(W-1){1'b0}}, p[i]};
      end
      m = nm;
      p = m << 1;
      k++;
    end
    return k;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; a_vec = '0; b_vec = '0;
    repeat (3) @(negedge clk);
    check(sum_vec == '0, "R1 sum", {1'b0, sum_vec}, '0);
    check(ovf_mask == '0, "R1 mask", {{(T-N+1){1'b0}}, ovf_mask}, '0);
    check(!carry_out && !done, "R1 flags", {carry_out, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // full operation with checks on the first add, the first pass, the end and the idle hold
  task automatic run_op(input logic [T-1:0] a, input logic [T-1:0] b, input string tag);
    logic [T:0] full;
    logic [T-1:0] s1;
    logic [N-1:0] m1;
    int k, cyc;
    full = {1'b0, a} + {1'b0, b};
    k = exp_passes(a, b);
    a_vec = a; b_vec = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    // R2: per-lane sums and carries
    for (int i = 0; i < N; i++) begin
      logic [W:0] ls;
      ls = {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]};
      check(sum_vec[i*W +: W] == ls[W-1:0], {"R2 lane sum ", tag}, sum_vec[i*W +: W], ls[W-1:0]);
      check(ovf_mask[i] == ls[W], {"R2 lane carry ", tag}, ovf_mask[i], ls[W]);
    end
    s1 = sum_vec; m1 = ovf_mask;
    if (k > 0) begin
      @(negedge clk);
      cyc++;
      // R3 / R4: one pass driven by the mask moved up one lane
      for (int i = 0; i < N; i++) begin
        logic pb;
        logic [W-1:0] es;
        pb = (i == 0) ? 1'b0 : m1[i-1];
        es = s1[i*W +: W] + {{(W-1){1'b0}}, pb};
        check(sum_vec[i*W +: W] == es, {"R3 pass lane ", tag}, sum_vec[i*W +: W], es);
        check(ovf_mask[i] == (pb & (&s1[i*W +: W])), {"R4 pass mask ", tag},
              ovf_mask[i], pb & (&s1[i*W +: W]));
      end
    end
    while (!done && cyc < N + 4) begin
      @(negedge clk);
      cyc++;
    end
    check(done, {"R5 done seen ", tag}, done, 1);
    check(cyc == k + 1, {"R7 latency ", tag}, cyc, k + 1);
    check(sum_vec == full[T-1:0], {"R5 sum ", tag}, {1'b0, sum_vec}, {1'b0, full[T-1:0]});
    check(ovf_mask[N-2:0] == '0, {"R5 mask clear ", tag}, ovf_mask, 0);
    check(carry_out == full[T], {"R6 carry ", tag}, carry_out, full[T]);
    a_vec = ~a; b_vec = ~b;
    @(negedge clk);
    check(!done, {"R5 pulse ", tag}, done, 0);
    @(negedge clk);
    check(sum_vec == full[T-1:0] && carry_out == full[T], {"R9 hold ", tag},
          {carry_out, sum_vec}, full);
  endtask

  // start while busy, and start in the done cycle, must both be ignored
  task automatic t_busy_start();
    logic [T-1:0] a, b;
    logic [T:0] full;
    int cyc = 0;
    a = '1; a[T-1 -: W] = '0;
    b = {{(T-1){1'b0}}, 1'b1};
    full = {1'b0, a} + {1'b0, b};
    a_vec = a; b_vec = b; start = 1'b1;
    @(negedge clk);
    a_vec = {N{32'h1111_1111}}; b_vec = a_vec;   // start held high mid-operation
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < N + 4) begin
      @(negedge clk);
      cyc++;
    end
    check(sum_vec == full[T-1:0], "R8 busy start ignored", {1'b0, sum_vec}, full);
    start = 1'b1;                                  // start in the done cycle
    @(negedge clk);
    start = 1'b0;
    check(!done && sum_vec == full[T-1:0], "R8 done-cycle start ignored", {done, sum_vec}, full);
    @(negedge clk);
    check(!done && sum_vec == full[T-1:0], "R8 no late launch", {done, sum_vec}, full);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [T-1:0] a, b;
    t_reset();
    run_op({N{32'h0000_0010}}, {N{32'h0000_0020}}, "nocarry");
    a = '0; a[W-1:0] = '1;
    run_op(a, {{(T-1){1'b0}}, 1'b1}, "single");
    a = '1; a[T-1 -: W] = '0;
    run_op(a, {{(T-1){1'b0}}, 1'b1}, "ripple");
    run_op('1, {{(T-1){1'b0}}, 1'b1}, "allones");
    a = '0; a[T-1 -: W] = 32'hF000_0000;
    run_op(a, a, "topcarry");
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++) begin
        a[i*W +: W] = $urandom();
        b[i*W +: W] = (i % 2 == 0) ? ~a[i*W +: W] : $urandom();
      end
      run_op(a, b, "mixed");
    end
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule